// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A write port loads a one-entry holding buffer. A shifter then takes the byte and sends it with a low start bit, eight data bits least significant bit first, an optional parity bit and one or two high stop bits. Between frames the line rests high. The bit rate is set by a one-cycle baud tick that comes from outside. Every line transition happens on the clock edge where that tick is high.

The empty flag reports the state of the holding buffer, not the state of the line. The flag rises on the tick where the byte moves into the shifter. At that moment the frame has only just started, so software can queue the next byte while the current one is still going out. When the holding buffer is full as the last stop bit ends, the next start bit follows on that same tick, with no gap. A level interrupt follows the empty flag, gated by an enable input.

Parity depends on the operating mode. A parity bit is inserted only in mode 0, and only when parity is enabled. Even or odd parity is selectable. Every other mode sends frames without a parity bit, whatever the parity-enable input says.

Top module: `uart_tx_buffered`

## Requirements
- R1: After reset, `txLine` is 1, `txEmpty` is 1 and `txIrq` equals `intEnable`.
- R2: A write (`wrEn`=1) accepted while `txEmpty` is 1 stores `wrData` and makes `txEmpty` 0 from the next cycle.
- R3: A write while `txEmpty` is 0 is ignored. The byte already held is the one that gets sent.
- R4: `txEmpty` returns to 1 in the cycle after the baud tick that moves the held byte into the shifter. In that cycle `txLine` already carries the start bit (0).
- R5: While `txEnable` is 0, a held byte is never moved: `txEmpty` stays 0 and the idle line stays 1.
- R6: A frame is a 0 start bit, then the 8 data bits least significant bit first, then stop bits of 1. Each bit lasts from one baud tick to the next, and the line is 1 when idle.
- R7: With `twoStop`=1 the frame ends with two stop bits. With `twoStop`=0 it ends with one.
- R8: With `opMode`=2'b00 and `parityOn`=1, a parity bit follows data bit 7. With `parityOdd`=0 it is the XOR of the data bits (even parity). With `parityOdd`=1 it is the inverse of that XOR (odd parity).
- R9: With `opMode` other than 2'b00, no parity bit is sent, even when `parityOn` is 1.
- R10: `txIrq` is 1 exactly when `txEmpty` is 1 and `intEnable` is 1.
- R11: If a byte is held when the last stop bit of a frame ends, its start bit begins on that same tick, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the holding buffer |
| wrData | input | DATA_W | Byte to transmit |
| txEnable | input | 1 | Allows bytes to move from the holding buffer to the shifter |
| intEnable | input | 1 | Interrupt enable |
| opMode | input | 2 | Operating mode; parity is possible only in mode 0 |
| parityOn | input | 1 | Parity enable (takes effect in mode 0 only) |
| parityOdd | input | 1 | 0 selects even parity, 1 selects odd parity |
| twoStop | input | 1 | 0 selects one stop bit, 1 selects two |
| baudTick | input | 1 | One-cycle strobe for each bit period |
| txLine | output | 1 | Serial output line |
| txEmpty | output | 1 | The holding buffer can accept a byte |
| txIrq | output | 1 | Interrupt request, as a level |

## Verification
The bench builds the block with the default `DATA_W` of 8 and drives a baud tick every four clocks. Each bit therefore lasts four cycles. That leaves room to check the empty flag in the exact cycle it changes, and to show that the flag rises while the start bit is on the line. A decoder in the bench rebuilds every frame, one sample per tick, and measures the idle run before each start bit. This covers parity and stop-bit errors, and also the zero-gap case when frames run back to back. Random bursts mix all four modes, both parity senses and both stop lengths, on top of directed cases for disabled transmit, writes to a full buffer, and parity being suppressed outside mode 0.

// File: rtl/utx_pkg.sv
package utx_pkg;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic loadHold;   // capture write data into the holding buffer
    logic loadShift;  // move held byte into the frame shifter
    logic shiftBit;   // advance the frame by one bit
  } utxStrobe_t;

  // Parity is inserted only in mode 0 and only when enabled
  function automatic logic parityActive(input logic [1:0] mode, input logic enable);
    return enable && (mode == 2'd0);
  endfunction

endpackage

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  utxStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              parEn,
  input  logic              parityOdd,
  output logic [DATA_W-1:0] holdData,
  output logic              txLine
);

  logic [FRAME_W-1:0] frameReg;
  logic [FRAME_W-1:0] frameNext;

  // Assemble start bit, data, optional parity; upper bits stay 1 as stop bits
  always_comb begin
    frameNext           = '1;
    frameNext[0]        = 1'b0;
    frameNext[DATA_W:1] = holdData;
    if (parEn) frameNext[DATA_W+1] = parityOdd ? ~(^holdData) : (^holdData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData <= '0;
      frameReg <= '1;
    end else begin
      if (strobe.loadHold) holdData <= wrData;
      if (strobe.loadShift)     frameReg <= frameNext;
      else if (strobe.shiftBit) frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
    end
  end

  assign txLine = frameReg[0];

endmodule

// File: rtl/utx_control.sv
module utx_control
  import utx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       txEnable,
  input  logic       baudTick,
  input  logic       parEn,
  input  logic       twoStop,
  output utxStrobe_t strobe,
  output logic       holdFull
);

  logic [CNT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] frameLen;
  logic             shifterIdle;
  logic             lastBit;

  // start + data + one stop, plus parity and an optional second stop
  assign frameLen    = CNT_W'(DATA_W + 2) + CNT_W'(parEn) + CNT_W'(twoStop);
  assign shifterIdle = (bitsLeft == '0);
  assign lastBit     = (bitsLeft == CNT_W'(1));

  always_comb begin
    strobe.loadHold  = wrEn && !holdFull;
    strobe.loadShift = baudTick && holdFull && txEnable && (shifterIdle || lastBit);
    strobe.shiftBit  = baudTick && !shifterIdle && !strobe.loadShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      bitsLeft <= '0;
    end else begin
      if (strobe.loadShift)     holdFull <= 1'b0;
      else if (strobe.loadHold) holdFull <= 1'b1;
      if (strobe.loadShift)     bitsLeft <= frameLen;
      else if (strobe.shiftBit) bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEnable,
  input  logic              intEnable,
  input  logic [1:0]        opMode,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              baudTick,
  output logic              txLine,
  output logic              txEmpty,
  output logic              txIrq
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  utxStrobe_t        strobe;
  logic              holdFull;
  logic              parEn;
  logic [DATA_W-1:0] holdData;

  assign parEn   = parityActive(opMode, parityOn);
  assign txEmpty = !holdFull;
  assign txIrq   = txEmpty && intEnable;

  utx_control #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .txEnable (txEnable),
    .baudTick (baudTick),
    .parEn    (parEn),
    .twoStop  (twoStop),
    .strobe   (strobe),
    .holdFull (holdFull)
  );

  utx_datapath #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .parEn     (parEn),
    .parityOdd (parityOdd),
    .holdData  (holdData),
    .txLine    (txLine)
  );

endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              txEnable,
  input logic              baudTick,
  input logic              txLine,
  input logic              txEmpty,
  input logic [DATA_W-1:0] holdData
);

  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txEmpty) |=> !txEmpty); // R2

  AST_FULL_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !txEmpty |=> $stable(holdData)); // R3

  AST_EMPTY_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> !txLine); // R4

  AST_DISABLED_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && !txEmpty) |=> !txEmpty); // R5

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(baudTick) |-> $stable(txLine)); // R6

endmodule

bind uart_tx_buffered utx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .txEnable (txEnable),
  .baudTick (baudTick),
  .txLine   (txLine),
  .txEmpty  (txEmpty),
  .holdData (holdData)
);

// File: tb/tb_uart_tx_buffered.sv
module tb_uart_tx_buffered;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       txEnable = 1'b0;
  logic       intEnable = 1'b0;
  logic [1:0] opMode = 2'd0;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       baudTick = 1'b0;
  logic       txLine, txEmpty, txIrq;

  int checks = 0;
  int failures = 0;
  int framesDone = 0;
  int idleRun = 0;
  int lastGap = 0;
  logic [7:0] expQ[$];

  uart_tx_buffered #(.DATA_W(8)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .txEnable(txEnable), .intEnable(intEnable), .opMode(opMode),
    .parityOn(parityOn), .parityOdd(parityOdd), .twoStop(twoStop),
    .baudTick(baudTick), .txLine(txLine), .txEmpty(txEmpty), .txIrq(txIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expParity(input logic [7:0] d, input logic odd);
    return odd ? ~(^d) : (^d);
  endfunction

  function automatic logic expParityOn(input logic [1:0] m, input logic en);
    return en && (m == 2'd0);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // baud tick generator: one cycle high every TICK_DIV cycles
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      baudTick = (cnt % TICK_DIV) == 0;
    end
  end

  task automatic getSample(output logic b);
    do @(posedge clk); while (!baudTick);
    @(negedge clk);
    b = txLine;
  endtask

  // frame decoder, one sample per tick
  initial begin
    logic b;
    logic [7:0] d;
    forever begin
      getSample(b);
      if (b) idleRun++;
      else begin
        logic [7:0] e;
        lastGap = idleRun;
        idleRun = 0;
        for (int i = 0; i < 8; i++) begin getSample(b); d[i] = b; end
        e = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
        check(d === e, "R6 data", d, e);
        if (expParityOn(opMode, parityOn)) begin
          getSample(b);
          check(b == expParity(e, parityOdd), "R8 parity", b, expParity(e, parityOdd));
        end
        getSample(b);
        check(b == 1'b1, "R6 R9 first stop", b, 1);
        if (twoStop) begin
          getSample(b);
          check(b == 1'b1, "R7 second stop", b, 1);
        end
        framesDone++;
      end
    end
  end

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    if (txEmpty) expQ.push_back(d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitFrames(input int n);
    while (framesDone < n) @(negedge clk);
    repeat (2 * TICK_DIV) @(negedge clk);
  endtask

  task automatic setCfg(input logic [1:0] m, input logic p, input logic o, input logic s);
    opMode = m; parityOn = p; parityOdd = o; twoStop = s;
  endtask

  // send two bytes back to back and require zero gap before the second
  task automatic backToBack(input logic [7:0] a, input logic [7:0] b2);
    int base = framesDone;
    writeByte(a);
    while (!txEmpty) @(negedge clk);
    writeByte(b2);
    waitFrames(base + 2);
    check(lastGap == 0, "R11 gap", lastGap, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1 line", txLine, 1);
    check(txEmpty == 1'b1, "R1 empty", txEmpty, 1);
    check(txIrq == 1'b0, "R1 irq", txIrq, 0);
    intEnable = 1'b1;
    #1 check(txIrq == 1'b1, "R10 irq when empty", txIrq, 1);

    // transmit disabled: write, then ignored second write
    writeByte(8'hA5);
    check(txEmpty == 1'b0, "R2 empty cleared", txEmpty, 0);
    check(txIrq == 1'b0, "R10 irq when full", txIrq, 1'b0);
    writeByte(8'h5A);  // R3: must be dropped
    repeat (10 * TICK_DIV) @(negedge clk);
    check(txEmpty == 1'b0, "R5 held while disabled", txEmpty, 0);
    check(txLine == 1'b1, "R5 line idle", txLine, 1);
    txEnable = 1'b1;
    while (!txEmpty) @(negedge clk);
    check(txLine == 1'b0, "R4 start bit at flag rise", txLine, 0);
    check(txIrq == 1'b1, "R10 irq at flag rise", txIrq, 1);
    waitFrames(1);
    check(expQ.size() == 0, "R3 only first byte sent", expQ.size(), 0);

    // even and odd parity in mode 0
    setCfg(2'd0, 1'b1, 1'b0, 1'b0);
    base = framesDone; writeByte(8'h01); waitFrames(base + 1);
    base = framesDone; writeByte(8'h03); waitFrames(base + 1);
    setCfg(2'd0, 1'b1, 1'b1, 1'b0);
    base = framesDone; writeByte(8'h01); waitFrames(base + 1);
    base = framesDone; writeByte(8'hF0); waitFrames(base + 1);

    // R9: parity enabled but modes 1 and 2 suppress it (0x03 would give parity 0)
    setCfg(2'd1, 1'b1, 1'b0, 1'b0);
    base = framesDone; writeByte(8'h03); waitFrames(base + 1);
    setCfg(2'd2, 1'b1, 1'b0, 1'b0);
    base = framesDone; writeByte(8'h81); waitFrames(base + 1);

    // R7 and R11: back to back with one and two stop bits
    setCfg(2'd0, 1'b0, 1'b0, 1'b0);
    backToBack(8'h3C, 8'hC3);
    setCfg(2'd0, 1'b0, 1'b0, 1'b1);
    backToBack(8'h96, 8'h69);
    setCfg(2'd0, 1'b1, 1'b1, 1'b1);
    backToBack(8'h00, 8'hFF);

    // random bursts
    for (int burst = 0; burst < 8; burst++) begin
      setCfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      base = framesDone;
      for (int k = 0; k < 5; k++) begin
        while (!txEmpty) @(negedge clk);
        writeByte(8'($urandom));
      end
      waitFrames(base + 5);
      check(expQ.size() == 0, "R6 burst drained", expQ.size(), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule